// File: doc/BRIEF.md
# Field-Synchronized Video Layer Controller

This block governs a single layer of a video compositing pipeline. A host programs the layer's settings through a small register write port into a shadow copy. It then requests an upload, and the shadow copy moves into the active set at the next frame-start strobe. An upload-ready flag tells the host when the active set has taken the new values and when the timing generator is running.

At every frame-start strobe the block works out the effective field parity. In interlaced scan this is the odd/even input. In progressive scan the parity is forced to even. From this parity the block decides two things. It decides whether a freshly enabled layer may switch on, which needs the programmed start-field bit XOR the parity to be 1. It also decides which of two fetch buffers the pixel DMA should read in the coming field.

The block drives the resulting layer-active flag, the buffer select and the active mixing settings. Pixel fetching, mixing and timing generation are handled elsewhere.

Top module: `vlayer_field_ctrl`

## Requirements
- R1: After reset `layer_active` and `buf_sel_b` are 0 and `act_cfg` is 7'h10: the start-field bit is 1 and every other setting is 0. `upload_ready` equals `tg_en`.
- R2: A write to the settings register (address 0) or the layer register (address 1) changes neither `act_cfg`, `layer_active` nor `buf_sel_b` until an upload is applied at a frame-start strobe. Settings register bits: 0 upsample enable, 1 interspersed chroma, 2 previous-alpha select, 3 premultiplied, 4 start field, 5 buffer toggle, 6 interlaced scan.
- R3: Writing the layer register with bit 1 set requests an upload, and `upload_ready` is 0 from the next cycle. At the next frame-start strobe the shadow settings and the enable (layer register bit 0) are copied to the active set, and `upload_ready` returns to 1 after that edge.
- R4: `upload_ready` is 0 in any cycle where `tg_en` is 0, whether or not a request is pending.
- R5: A layer that is active-enabled but not yet on switches on at a frame-start strobe only when start-field XOR the effective parity is 1 (`field_odd` = 1 means an odd field). Otherwise it stays off until a later strobe meets the condition. Once on, it stays on while enabled.
- R6: With interlaced scan clear the effective parity is 0, so the layer switches on only if the start-field bit is 1, whatever `field_odd` shows.
- R7: When the active enable is 0 at a frame-start strobe, `layer_active` goes to 0 after that edge, regardless of parity or start field.
- R8: At each frame-start strobe `buf_sel_b` becomes 1 (buffer B) when the buffer toggle bit is set and the effective parity is even. It becomes 0 (buffer A) in odd fields or when the toggle bit is clear.
- R9: Register writes made while an upload is pending are accepted. The copy takes the shadow contents present just before the strobe edge.
- R10: A request written in the same cycle as a strobe with no upload pending copies nothing at that strobe. The copy happens at the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 settings, 1 layer) |
| wr_data | input | DATA_W | Register write data |
| field_odd | input | 1 | Field parity from timing, 1 = odd field |
| frame_start | input | 1 | One-cycle strobe at each field start |
| tg_en | input | 1 | Screen timing generator running |
| layer_active | output | 1 | Layer enabled for the current field |
| buf_sel_b | output | 1 | Fetch buffer select, 1 = buffer B |
| act_cfg | output | 7 | Active settings, same bit layout as the settings register |
| upload_ready | output | 1 | 1 = new upload may start |

## Verification
The bench builds the block with its defaults: a 4-bit address, an 8-bit data word, the settings register at address 0, and the enable and request bits at positions 0 and 1 of address 1. These defaults expose every settings bit on `act_cfg`, so each upload can be compared bit for bit. The strobe sequence reaches both scan modes, both start-field values and both parities. It also covers the overlap of a request with a strobe and register writes made while an upload is pending.

// File: rtl/vlayer_pkg.sv
`timescale 1ns/1ps
package vlayer_pkg;

  typedef struct packed {
    logic interlaced;
    logic buf_toggle;
    logic start_field;
    logic premult;
    logic alpha_prev;
    logic chroma_isp;
    logic ups_en;
  } layer_cfg_t;

  localparam int CFG_W = $bits(layer_cfg_t);

  localparam layer_cfg_t CFG_RST = '{
    interlaced:  1'b0,
    buf_toggle:  1'b0,
    start_field: 1'b1,
    premult:     1'b0,
    alpha_prev:  1'b0,
    chroma_isp:  1'b0,
    ups_en:      1'b0
  };

  // Progressive scan pins the parity to even.
  function automatic logic f_eff_parity(input logic interlaced, input logic odd);
    return interlaced & odd;
  endfunction

  // Start gate for a layer that is enabled but still off.
  function automatic logic f_start_gate(input logic start_field, input logic eff_odd);
    return start_field ^ eff_odd;
  endfunction

  // 1 selects buffer B, which is used in even fields when toggling.
  function automatic logic f_pick_b(input logic toggle, input logic eff_odd);
    return toggle & ~eff_odd;
  endfunction

endpackage

// File: rtl/vlayer_shadow_regs.sv
`timescale 1ns/1ps
module vlayer_shadow_regs
  import vlayer_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CFG_ADDR   = 0,
  parameter int LAYER_ADDR = 1,
  parameter int EN_BIT     = 0,
  parameter int REQ_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output layer_cfg_t        shd_cfg,
  output logic              shd_en,
  output logic              req_pulse
);

  localparam logic [ADDR_W-1:0] CFG_A   = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] LAYER_A = ADDR_W'(LAYER_ADDR);

  logic hit_cfg;
  logic hit_layer;
  logic unused_wr;

  assign hit_cfg   = wr_en && (wr_addr == CFG_A);
  assign hit_layer = wr_en && (wr_addr == LAYER_A);
  assign req_pulse = hit_layer && wr_data[REQ_BIT];
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_cfg <= CFG_RST;
      shd_en  <= 1'b0;
    end else begin
      if (hit_cfg)   shd_cfg <= layer_cfg_t'(wr_data[CFG_W-1:0]);
      if (hit_layer) shd_en  <= wr_data[EN_BIT];
    end
  end

  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_cfg |=> $stable(shd_cfg));
  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_layer |=> $stable(shd_en));

endmodule

// File: rtl/vlayer_upload_ctrl.sv
`timescale 1ns/1ps
module vlayer_upload_ctrl
  import vlayer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  layer_cfg_t shd_cfg,
  input  logic       shd_en,
  input  logic       req_pulse,
  input  logic       frame_start,
  input  logic       tg_en,
  output layer_cfg_t act_cfg,
  output logic       act_en,
  output layer_cfg_t nxt_cfg,
  output logic       nxt_en,
  output logic       copy_stb,
  output logic       upload_ready
);

  logic pend_q;
  logic pend_d;

  assign copy_stb     = frame_start & pend_q;
  assign pend_d       = req_pulse | (pend_q & ~frame_start);
  assign nxt_cfg      = copy_stb ? shd_cfg : act_cfg;
  assign nxt_en       = copy_stb ? shd_en  : act_en;
  assign upload_ready = tg_en & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      act_cfg <= CFG_RST;
      act_en  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (copy_stb) begin
        act_cfg <= shd_cfg;
        act_en  <= shd_en;
      end
    end
  end

  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_stb |=> ($stable(act_cfg) && $stable(act_en)));
  p_request_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !upload_ready);
  p_copy_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_stb && !req_pulse) |=> !pend_q);
  p_late_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pend_q) |=> $stable(act_cfg));
  p_ready_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tg_en |-> !upload_ready);

endmodule

// File: rtl/vlayer_field_gate.sv
`timescale 1ns/1ps
module vlayer_field_gate
  import vlayer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       field_odd,
  input  layer_cfg_t nxt_cfg,
  input  logic       nxt_en,
  output logic       layer_active,
  output logic       buf_sel_b
);

  logic eff_odd;
  logic start_ok;
  logic active_d;

  assign eff_odd  = f_eff_parity(nxt_cfg.interlaced, field_odd);
  assign start_ok = f_start_gate(nxt_cfg.start_field, eff_odd);

  always_comb begin
    active_d = layer_active;
    if (frame_start) begin
      if (!nxt_en)            active_d = 1'b0;
      else if (!layer_active) active_d = start_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layer_active <= 1'b0;
      buf_sel_b    <= 1'b0;
    end else begin
      layer_active <= active_d;
      if (frame_start) buf_sel_b <= f_pick_b(nxt_cfg.buf_toggle, eff_odd);
    end
  end

  p_off_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !nxt_en) |=> !layer_active);
  p_on_at_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(layer_active) |-> $past(frame_start));
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(layer_active) && $stable(buf_sel_b)));
  p_prog_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && nxt_en && !layer_active && !nxt_cfg.interlaced
     && !nxt_cfg.start_field) |=> !layer_active);
  p_buf_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !nxt_cfg.buf_toggle) |=> !buf_sel_b);

endmodule

// File: rtl/vlayer_field_ctrl.sv
`timescale 1ns/1ps
module vlayer_field_ctrl
  import vlayer_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CFG_ADDR   = 0,
  parameter int LAYER_ADDR = 1,
  parameter int EN_BIT     = 0,
  parameter int REQ_BIT    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   field_odd,
  input  logic                   frame_start,
  input  logic                   tg_en,
  output logic                   layer_active,
  output logic                   buf_sel_b,
  output logic [CFG_W-1:0]       act_cfg,
  output logic                   upload_ready
);

  layer_cfg_t shd_cfg;
  layer_cfg_t act_cfg_s;
  layer_cfg_t nxt_cfg;
  logic       shd_en;
  logic       act_en;
  logic       nxt_en;
  logic       req_pulse;
  logic       copy_stb;

  vlayer_shadow_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .LAYER_ADDR(LAYER_ADDR), .EN_BIT(EN_BIT), .REQ_BIT(REQ_BIT)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shd_cfg(shd_cfg), .shd_en(shd_en),
    .req_pulse(req_pulse)
  );

  vlayer_upload_ctrl u_upload (
    .clk(clk), .rst_n(rst_n), .shd_cfg(shd_cfg), .shd_en(shd_en),
    .req_pulse(req_pulse), .frame_start(frame_start), .tg_en(tg_en),
    .act_cfg(act_cfg_s), .act_en(act_en), .nxt_cfg(nxt_cfg),
    .nxt_en(nxt_en), .copy_stb(copy_stb), .upload_ready(upload_ready)
  );

  vlayer_field_gate u_gate (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .field_odd(field_odd), .nxt_cfg(nxt_cfg), .nxt_en(nxt_en),
    .layer_active(layer_active), .buf_sel_b(buf_sel_b)
  );

  assign act_cfg = act_cfg_s;

  p_active_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_active && !act_en) |-> !$past(frame_start));
  p_settle_after_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_stb && !req_pulse && tg_en) |=> (upload_ready || !tg_en));

endmodule

// File: tb/vlayer_field_ctrl_bench.sv
`timescale 1ns/1ps
module vlayer_field_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       field_odd = 1'b0;
  logic       frame_start = 1'b0;
  logic       tg_en = 1'b1;
  logic       layer_active;
  logic       buf_sel_b;
  logic [6:0] act_cfg;
  logic       upload_ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  vlayer_field_ctrl u_vlayer_field_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .field_odd(field_odd), .frame_start(frame_start),
    .tg_en(tg_en), .layer_active(layer_active), .buf_sel_b(buf_sel_b),
    .act_cfg(act_cfg), .upload_ready(upload_ready)
  );

  // {wr, addr[3:0], data[7:0], fs, odd, exp_active, exp_buf_b, exp_ready}
  localparam int NV = 23;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b1, 4'd0, 8'h70, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 shadow only
    {1'b1, 4'd1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 enable w/o request
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 strobe w/o upload
    {1'b1, 4'd1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 request
    {1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 still busy
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 odd, start1 -> off; R8 A
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 even -> on; R8 B
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 stays; R8 A
    {1'b1, 4'd0, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2
    {1'b1, 4'd1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 disable request
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 off
    {1'b1, 4'd1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 start0 even -> off
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 odd -> on
    {1'b1, 4'd1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 off in odd field
    {1'b1, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 progressive, start0
    {1'b1, 4'd1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 parity forced 0 -> off
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 still off
    {1'b1, 4'd0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 start1
    {1'b1, 4'd1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}  // R6 on although odd shown
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, let the edge pass, return at the next negedge.
  task automatic step(input bit wr, input logic [3:0] a, input logic [7:0] d,
                      input bit fs, input bit odd);
    wr_en = wr; wr_addr = a; wr_data = d; frame_start = fs; field_odd = odd;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 active", int'(layer_active), 0);
    check("R1 buf", int'(buf_sel_b), 0);
    check("R1 cfg", int'(act_cfg), 'h10);
    check("R1 ready", int'(upload_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(upload_ready), 1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16:13], VEC[i][12:5], VEC[i][4], VEC[i][3]);
      check($sformatf("R5/R7 vec%0d active", i), int'(layer_active), int'(VEC[i][2]));
      check($sformatf("R8 vec%0d buf", i), int'(buf_sel_b), int'(VEC[i][1]));
      check($sformatf("R3 vec%0d ready", i), int'(upload_ready), int'(VEC[i][0]));
    end
    check("R2 cfg after table", int'(act_cfg), 'h10);

    // R4: timing generator off
    tg_en = 1'b0;
    #1 check("R4 idle off", int'(upload_ready), 0);
    step(1'b1, 4'd1, 8'h03, 1'b0, 1'b0);
    check("R4 pending off", int'(upload_ready), 0);
    tg_en = 1'b1;
    #1 check("R4 pending on", int'(upload_ready), 0);
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check("R3 done", int'(upload_ready), 1);

    // R10: request coinciding with a strobe
    step(1'b1, 4'd0, 8'h18, 1'b0, 1'b0);
    step(1'b1, 4'd1, 8'h03, 1'b1, 1'b0);
    check("R10 no copy", int'(act_cfg), 'h10);
    check("R10 busy", int'(upload_ready), 0);
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check("R10 copied", int'(act_cfg), 'h18);
    check("R10 ready", int'(upload_ready), 1);

    // R9: write while pending lands in the copy
    step(1'b1, 4'd1, 8'h03, 1'b0, 1'b0);
    step(1'b1, 4'd0, 8'h1C, 1'b0, 1'b0);
    check("R9 not yet", int'(act_cfg), 'h18);
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check("R9 latest value", int'(act_cfg), 'h1C);

    // R8 with R6: progressive scan toggling picks B regardless of field_odd
    step(1'b1, 4'd0, 8'h30, 1'b0, 1'b0);
    step(1'b1, 4'd1, 8'h03, 1'b0, 1'b0);
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1);
    check("R8 progressive B", int'(buf_sel_b), 1);
    check("R6 stays on", int'(layer_active), 1);

    done = 1'b1;
    finish_run();
  end

endmodule